// File: doc/BRIEF.md
# SMBus Target Transaction Decoder

This block is the protocol layer of an SMBus target. It consumes an already decoded stream of bus events: a start addressed for writing, a start addressed for reading, a written byte, a request for a byte to read, a NACK from the controller and a stop. It turns that stream into operations for a device back end. A target cannot tell a word write from a short block write, so it does not try to. Written bytes are collected in a buffer. The kind of write is decided only when the stop or the repeated start arrives, from how many bytes were collected.

Reads are answered one byte at a time. A plain receive-byte read asks the back end for a single value. A read that follows a written command asks for the byte at (latched command, running index), and the index advances after each byte. An illegal event sequence parks the machine in an error state. Only a stop releases it. The bench and the back end present at most one event per cycle.

Top module: `smbus_tgt_fsm`

## Requirements
- R1: After reset the block reports no operation (`op_valid_o`=0), no read response (`rd_valid_o`=0), not confused (`confused_o`=0), no overflow and no unexpected stop.
- R2: A write-start while idle begins collecting write bytes. A write-start in any other state makes `confused_o` 1.
- R3: A stop while collecting pulses `op_valid_o` in the following cycle. With 0 bytes the kind is quick write (`op_kind_o`=0). With 1 byte it is send byte (kind 2, `op_cmd_o`=the byte). With more bytes it is command write (kind 3): `op_cmd_o` is the first byte, `op_len_o` is the count minus one, and payload byte k is read from `pay_data_o` with `pay_idx_i`=k.
- R4: A read-start while idle enters single-byte receive. A stop there with no byte read reports quick read (kind 1).
- R5: A read-start while collecting behaves as follows. With 0 bytes it makes `confused_o` 1. With 1 byte it latches that byte as the command and reports no operation. With more bytes it reports the command write first (as in R3). In both non-zero cases the read index returns to 0 and indexed reads begin.
- R6: A read request in single-byte receive raises `be_rd_req_o` with `be_rd_kind_o`=0. The back-end byte appears on `rd_data_o` with `rd_valid_o` one cycle later, and further reads are not served. In indexed reads each request raises `be_rd_req_o` with `be_rd_kind_o`=1, the latched command and the current index, and the index then increments.
- R7: A NACK during indexed reads ends the read. A NACK after the read has ended is ignored. A NACK in any other state makes `confused_o` 1.
- R8: A read request in any state other than single-byte receive or indexed reads returns 0 with `rd_valid_o`, raises no back-end request and makes `confused_o` 1. A written byte outside write collection is discarded.
- R9: Once confused, the block stays confused through every event except a stop. A stop returns it to idle.
- R10: The buffer keeps the first MAX_DATA+2 written bytes of a write. Later bytes are dropped, and `overflow_o` is set and stays set until reset.
- R11: Every stop returns the block to idle with an empty buffer. A stop during indexed reads also pulses `unexp_stop_o` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_wr_i | input | 1 | Start (or repeated start) addressed for writing |
| start_rd_i | input | 1 | Start (or repeated start) addressed for reading |
| wr_i | input | 1 | Controller wrote a byte |
| wr_data_i | input | 8 | Written byte |
| rd_i | input | 1 | Controller requests a byte |
| nack_i | input | 1 | Controller NACKed a read byte |
| stop_i | input | 1 | Stop condition |
| rd_valid_o | output | 1 | Read response valid (one cycle after rd_i) |
| rd_data_o | output | 8 | Read response byte |
| be_rd_req_o | output | 1 | Back-end read request (same cycle as rd_i) |
| be_rd_kind_o | output | 1 | 0 receive byte, 1 indexed read |
| be_rd_cmd_o | output | 8 | Latched command for indexed reads |
| be_rd_idx_o | output | IDX_W | Running read index |
| be_rd_data_i | input | 8 | Back-end read byte |
| op_valid_o | output | 1 | Operation pulse |
| op_kind_o | output | 2 | 0 quick write, 1 quick read, 2 send byte, 3 command write |
| op_cmd_o | output | 8 | Command or sent byte |
| op_len_o | output | CNT_W | Payload byte count for command writes |
| pay_idx_i | input | CNT_W | Payload byte select |
| pay_data_o | output | 8 | Selected payload byte |
| confused_o | output | 1 | Error state |
| overflow_o | output | 1 | Sticky write buffer overflow |
| unexp_stop_o | output | 1 | Stop arrived during indexed reads |

## Verification
The assertions check some properties on every cycle. Operations appear only after a stop or a read-start. Read responses follow only read requests. The error flag falls only after a stop. The overflow flag never clears. A read answered while confused returns zero. The bench scenarios cover the rest, because the assertions cannot see it: the decoding of write kind by byte count, the latching of the command on a repeated start, the running read index, the ignored NACK after a read ends, and the discarding of stray written bytes, which is observed through the next quick write.

// File: rtl/smbus_tgt_pkg.sv
package smbus_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WDATA, ST_RECV, ST_RDATA, ST_DONE, ST_CONF
  } st_e;

  typedef enum logic [1:0] {
    OP_QUICK_WR = 2'd0,
    OP_QUICK_RD = 2'd1,
    OP_SEND     = 2'd2,
    OP_CMD_WR   = 2'd3
  } op_e;

  typedef struct packed {
    logic start_wr;
    logic start_rd;
    logic wr;
    logic rd;
    logic nack;
    logic stop;
  } ev_t;
endpackage

// File: rtl/smbus_tgt_wbuf.sv
module smbus_tgt_wbuf #(
  parameter int unsigned DEPTH = 34,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [7:0]       data_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       head_o,
  output logic [7:0]       rd_data_o,
  output logic             ovf_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full;

  assign full = (cnt_q >= CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      if (full) ovf_q <= 1'b1;
      else      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_i && !clr_i && (cnt_q == CNT_W'(g))) mem_q[g] <= data_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign ovf_o     = ovf_q;
  assign head_o    = mem_q[0];
  assign rd_data_o = (rd_idx_i < CNT_W'(DEPTH)) ? mem_q[rd_idx_i] : 8'h00;
endmodule

// File: rtl/smbus_tgt_ctrl.sv
module smbus_tgt_ctrl
  import smbus_tgt_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ev_t              ev_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [7:0]       head_i,
  output logic             push_o,
  output logic             clr_o,
  output logic             cmd_ld_o,
  output logic             idx_clr_o,
  output logic             idx_inc_o,
  output logic             serve_o,
  output logic             rd_kind_o,
  output logic             confused_o,
  output logic             unexp_o,
  output logic             op_valid_o,
  output op_e              op_kind_o,
  output logic [7:0]       op_cmd_o,
  output logic [CNT_W-1:0] op_len_o
);
  st_e  st_q, st_d;
  logic fire;
  op_e  kind;
  logic unexp_d;

  always_comb begin
    st_d      = st_q;
    push_o    = 1'b0;
    clr_o     = 1'b0;
    cmd_ld_o  = 1'b0;
    idx_clr_o = 1'b0;
    idx_inc_o = 1'b0;
    serve_o   = 1'b0;
    rd_kind_o = 1'b0;
    fire      = 1'b0;
    kind      = OP_QUICK_WR;
    unexp_d   = 1'b0;
    if (ev_i.stop) begin
      clr_o = 1'b1;
      st_d  = ST_IDLE;
      unique case (st_q)
        ST_WDATA: begin
          fire = 1'b1;
          if (cnt_i == '0)                kind = OP_QUICK_WR;
          else if (cnt_i == CNT_W'(1))    kind = OP_SEND;
          else                            kind = OP_CMD_WR;
        end
        ST_RECV:  begin fire = 1'b1; kind = OP_QUICK_RD; end
        ST_RDATA: unexp_d = 1'b1;
        default: ;
      endcase
    end else if (ev_i.start_wr) begin
      st_d = (st_q == ST_IDLE) ? ST_WDATA : ST_CONF;
    end else if (ev_i.start_rd) begin
      if (st_q == ST_IDLE) st_d = ST_RECV;
      else if (st_q == ST_WDATA && cnt_i != '0) begin
        cmd_ld_o  = 1'b1;
        fire      = (cnt_i > CNT_W'(1));
        kind      = OP_CMD_WR;
        clr_o     = 1'b1;
        idx_clr_o = 1'b1;
        st_d      = ST_RDATA;
      end else st_d = ST_CONF;
    end else if (ev_i.nack) begin
      if (st_q == ST_RDATA)     st_d = ST_DONE;
      else if (st_q != ST_DONE) st_d = ST_CONF;
    end else if (ev_i.rd) begin
      if (st_q == ST_RECV) begin
        serve_o = 1'b1;
        st_d    = ST_DONE;
      end else if (st_q == ST_RDATA) begin
        serve_o   = 1'b1;
        rd_kind_o = 1'b1;
        idx_inc_o = 1'b1;
      end else st_d = ST_CONF;
    end else if (ev_i.wr) begin
      push_o = (st_q == ST_WDATA);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      op_valid_o <= 1'b0;
      op_kind_o  <= OP_QUICK_WR;
      op_cmd_o   <= '0;
      op_len_o   <= '0;
      unexp_o    <= 1'b0;
    end else begin
      st_q       <= st_d;
      op_valid_o <= fire;
      unexp_o    <= unexp_d;
      if (fire) begin
        op_kind_o <= kind;
        op_cmd_o  <= (kind == OP_SEND || kind == OP_CMD_WR) ? head_i : 8'h00;
        op_len_o  <= (kind == OP_CMD_WR) ? cnt_i - CNT_W'(1) : '0;
      end
    end
  end

  assign confused_o = (st_q == ST_CONF);
endmodule

// File: rtl/smbus_tgt_rdpath.sv
module smbus_tgt_rdpath #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_ld_i,
  input  logic [7:0]       cmd_i,
  input  logic             idx_clr_i,
  input  logic             idx_inc_i,
  input  logic             req_i,
  input  logic             serve_i,
  input  logic [7:0]       be_data_i,
  output logic [7:0]       cmd_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= '0;
      idx_o      <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      if (cmd_ld_i)       cmd_o <= cmd_i;
      if (idx_clr_i)      idx_o <= '0;
      else if (idx_inc_i) idx_o <= idx_o + IDX_W'(1);
      rd_valid_o <= req_i;
      if (req_i) rd_data_o <= serve_i ? be_data_i : 8'h00;
    end
  end
endmodule

// File: rtl/smbus_tgt_fsm.sv
module smbus_tgt_fsm
  import smbus_tgt_pkg::*;
#(
  parameter  int unsigned MAX_DATA = 32,
  parameter  int unsigned IDX_W    = 6,
  localparam int unsigned DEPTH    = MAX_DATA + 2,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_wr_i,
  input  logic             start_rd_i,
  input  logic             wr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_i,
  input  logic             nack_i,
  input  logic             stop_i,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             be_rd_req_o,
  output logic             be_rd_kind_o,
  output logic [7:0]       be_rd_cmd_o,
  output logic [IDX_W-1:0] be_rd_idx_o,
  input  logic [7:0]       be_rd_data_i,
  output logic             op_valid_o,
  output logic [1:0]       op_kind_o,
  output logic [7:0]       op_cmd_o,
  output logic [CNT_W-1:0] op_len_o,
  input  logic [CNT_W-1:0] pay_idx_i,
  output logic [7:0]       pay_data_o,
  output logic             confused_o,
  output logic             overflow_o,
  output logic             unexp_stop_o
);
  ev_t              ev;
  logic             push, clr, cmd_ld, idx_clr, idx_inc, serve, rd_kind;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       head;
  logic [CNT_W-1:0] buf_idx;
  op_e              op_kind;

  assign ev = '{start_wr: start_wr_i, start_rd: start_rd_i, wr: wr_i,
                rd: rd_i, nack: nack_i, stop: stop_i};
  // payload starts after the command byte
  assign buf_idx = pay_idx_i + CNT_W'(1);

  smbus_tgt_wbuf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_wbuf (
    .clk_i, .rst_ni,
    .push_i(push), .data_i(wr_data_i), .clr_i(clr),
    .rd_idx_i(buf_idx), .cnt_o(cnt), .head_o(head),
    .rd_data_o(pay_data_o), .ovf_o(overflow_o)
  );

  smbus_tgt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .ev_i(ev), .cnt_i(cnt), .head_i(head),
    .push_o(push), .clr_o(clr), .cmd_ld_o(cmd_ld),
    .idx_clr_o(idx_clr), .idx_inc_o(idx_inc),
    .serve_o(serve), .rd_kind_o(rd_kind),
    .confused_o(confused_o), .unexp_o(unexp_stop_o),
    .op_valid_o(op_valid_o), .op_kind_o(op_kind),
    .op_cmd_o(op_cmd_o), .op_len_o(op_len_o)
  );

  smbus_tgt_rdpath #(.IDX_W(IDX_W)) u_rdpath (
    .clk_i, .rst_ni,
    .cmd_ld_i(cmd_ld), .cmd_i(head),
    .idx_clr_i(idx_clr), .idx_inc_i(idx_inc),
    .req_i(rd_i && !stop_i && !start_wr_i && !start_rd_i && !nack_i),
    .serve_i(serve), .be_data_i(be_rd_data_i),
    .cmd_o(be_rd_cmd_o), .idx_o(be_rd_idx_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  assign op_kind_o    = op_kind;
  assign be_rd_req_o  = serve;
  assign be_rd_kind_o = rd_kind;
endmodule

// File: rtl/smbus_tgt_fsm_chk.sv
module smbus_tgt_fsm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_rd_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic       stop_i,
  input logic       op_valid_o,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       be_rd_req_o,
  input logic       confused_o,
  input logic       overflow_o,
  input logic       unexp_stop_o
);
  AST_OP_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(stop_i || start_rd_i)); // R3
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_i)); // R6
  AST_REQ_NEEDS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_rd_req_o |-> (rd_i && !confused_o)); // R6
  AST_CONF_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(confused_o)) |-> (rd_data_o == 8'h00)); // R8
  AST_CONF_EXIT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(confused_o) |-> $past(stop_i)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(overflow_o) |-> overflow_o); // R10
  AST_OVF_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(wr_i)); // R10
  AST_UNEXP_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unexp_stop_o |-> $past(stop_i)); // R11
endmodule

bind smbus_tgt_fsm smbus_tgt_fsm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_rd_i(start_rd_i), .rd_i(rd_i),
  .wr_i(wr_i), .stop_i(stop_i), .op_valid_o(op_valid_o),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .be_rd_req_o(be_rd_req_o),
  .confused_o(confused_o), .overflow_o(overflow_o), .unexp_stop_o(unexp_stop_o)
);

// File: tb/smbus_tgt_fsm_bench.sv
`timescale 1ns/1ps
module smbus_tgt_fsm_bench;
  localparam int CNT_W = 6;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_wr = 0, start_rd = 0, wr = 0, rd = 0, nack = 0, stop = 0;
  logic [7:0] wr_data = '0;
  logic [CNT_W-1:0] pay_idx = '0;
  logic rd_valid, be_req, be_kind, op_valid, confused, overflow, unexp;
  logic [7:0] rd_data, be_cmd, be_data, op_cmd, pay_data;
  logic [IDX_W-1:0] be_idx;
  logic [1:0] op_kind;
  logic [CNT_W-1:0] op_len;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  // back-end model: fixed receive byte, indexed reads return cmd+idx
  assign be_data = be_kind ? (be_cmd + {2'b00, be_idx}) : 8'hA5;

  smbus_tgt_fsm u_smbus_tgt_fsm (
    .clk_i(clk), .rst_ni(rst_n),
    .start_wr_i(start_wr), .start_rd_i(start_rd), .wr_i(wr), .wr_data_i(wr_data),
    .rd_i(rd), .nack_i(nack), .stop_i(stop),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .be_rd_req_o(be_req), .be_rd_kind_o(be_kind), .be_rd_cmd_o(be_cmd),
    .be_rd_idx_o(be_idx), .be_rd_data_i(be_data),
    .op_valid_o(op_valid), .op_kind_o(op_kind), .op_cmd_o(op_cmd), .op_len_o(op_len),
    .pay_idx_i(pay_idx), .pay_data_o(pay_data),
    .confused_o(confused), .overflow_o(overflow), .unexp_stop_o(unexp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int which, input logic [7:0] d = 8'h00);
    @(negedge clk);
    wr_data = d;
    case (which)
      0: start_wr = 1; 1: start_rd = 1; 2: wr = 1;
      3: rd = 1;       4: nack = 1;     default: stop = 1;
    endcase
    @(negedge clk);
    {start_wr, start_rd, wr, rd, nack, stop} = '0;
  endtask

  task automatic do_rd(input bit served, input bit kind, input int idx,
                       input int exp, input string tag);
    @(negedge clk);
    rd = 1;
    #1;
    chk(be_req == served, {tag, " req"}, be_req, served);
    if (served) begin
      chk(be_kind == kind, {tag, " kind"}, be_kind, kind);
      if (kind) chk(be_idx == idx, {tag, " idx"}, be_idx, idx);
    end
    @(negedge clk);
    rd = 0;
    chk(rd_valid && rd_data == exp, {tag, " data"}, rd_data, exp);
  endtask

  task automatic exp_op(input int kind, input int cmd, input int len, input string tag);
    chk(op_valid == 1'b1, {tag, " op_valid"}, op_valid, 1);
    chk(op_kind == kind, {tag, " op_kind"}, op_kind, kind);
    chk(op_cmd == cmd, {tag, " op_cmd"}, op_cmd, cmd);
    chk(op_len == len, {tag, " op_len"}, op_len, len);
  endtask

  task automatic t_reset();
    #1;
    chk(!op_valid && !rd_valid && !confused && !overflow && !unexp, "R1 reset", 1, 0);
  endtask

  task automatic t_quick_wr();
    pulse(0); pulse(5);
    exp_op(0, 0, 0, "R2 R3 quick write");
    chk(!confused, "R2 no confuse", confused, 0);
  endtask

  task automatic t_send_byte();
    pulse(0); pulse(2, 8'h3C); pulse(5);
    exp_op(2, 8'h3C, 0, "R3 send byte");
  endtask

  task automatic t_cmd_write();
    pulse(0); pulse(2, 8'h10); pulse(2, 8'hAA); pulse(2, 8'hBB); pulse(5);
    exp_op(3, 8'h10, 2, "R3 cmd write");
    pay_idx = 0; #1 chk(pay_data == 8'hAA, "R3 pay0", pay_data, 8'hAA);
    pay_idx = 1; #1 chk(pay_data == 8'hBB, "R3 pay1", pay_data, 8'hBB);
  endtask

  task automatic t_recv_byte();
    pulse(1);
    do_rd(1, 0, 0, 8'hA5, "R6 recv byte");
    pulse(4);
    chk(!confused, "R7 nack in done ignored", confused, 0);
    pulse(5);
    chk(!op_valid && !unexp, "R11 stop after recv", op_valid, 0);
    pulse(1); pulse(3);
    pulse(3);
    chk(confused, "R8 read after done", confused, 1);
    pulse(5);
  endtask

  task automatic t_quick_rd();
    pulse(1); pulse(5);
    exp_op(1, 0, 0, "R4 quick read");
  endtask

  task automatic t_rd_one_cmd();
    pulse(0); pulse(2, 8'h20); pulse(1);
    chk(!op_valid && !confused, "R5 one byte latches cmd", op_valid, 0);
    for (int k = 0; k < 3; k++) begin
      #1 chk(be_cmd == 8'h20, "R6 latched cmd", be_cmd, 8'h20);
      do_rd(1, 1, k, 8'h20 + k, "R6 indexed read");
    end
    pulse(4); pulse(4);
    chk(!confused, "R7 nack after nack", confused, 0);
    pulse(5);
    chk(!unexp, "R11 no unexp after done", unexp, 0);
  endtask

  task automatic t_rd_multi_cmd();
    pulse(0); pulse(2, 8'h30); pulse(2, 8'h01); pulse(2, 8'h02); pulse(1);
    exp_op(3, 8'h30, 2, "R5 write before read");
    do_rd(1, 1, 0, 8'h30, "R5 index cleared");
    pulse(4); pulse(5);
  endtask

  task automatic t_rd_empty();
    pulse(0); pulse(1);
    chk(confused, "R5 read-start empty", confused, 1);
    pulse(2, 8'h77); pulse(0); pulse(4); pulse(1);
    chk(confused, "R9 confused holds", confused, 1);
    do_rd(0, 0, 0, 0, "R8 read in confused");
    pulse(5);
    chk(!confused, "R9 stop releases", confused, 0);
    pulse(0); pulse(5);
    exp_op(0, 0, 0, "R9 R11 after release");
  endtask

  task automatic t_bad_starts();
    pulse(1); pulse(0);
    chk(confused, "R2 write-start not idle", confused, 1);
    pulse(5);
    pulse(4);
    chk(confused, "R7 nack in idle", confused, 1);
    pulse(5);
    do_rd(0, 0, 0, 0, "R8 read in idle");
    chk(confused, "R8 read in idle confuses", confused, 1);
    pulse(5);
    pulse(2, 8'h55); pulse(0); pulse(5);
    exp_op(0, 0, 0, "R8 stray write discarded");
  endtask

  task automatic t_unexp_stop();
    pulse(0); pulse(2, 8'h40); pulse(1);
    do_rd(1, 1, 0, 8'h40, "R6 before stop");
    pulse(5);
    chk(unexp, "R11 unexpected stop", unexp, 1);
    chk(!op_valid, "R11 no op", op_valid, 0);
    pulse(0); pulse(5);
    chk(!unexp, "R11 pulse only", unexp, 0);
    exp_op(0, 0, 0, "R11 buffer cleared");
  endtask

  task automatic t_overflow();
    pulse(0);
    for (int k = 0; k < 34; k++) pulse(2, 8'(k + 1));
    chk(!overflow, "R10 full no overflow", overflow, 0);
    pulse(2, 8'hEE);
    chk(overflow, "R10 overflow set", overflow, 1);
    pulse(5);
    exp_op(3, 8'h01, 33, "R10 kept bytes");
    pay_idx = 32; #1 chk(pay_data == 8'd34, "R10 last kept", pay_data, 34);
    pulse(0); pulse(5);
    chk(overflow, "R10 sticky", overflow, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_quick_wr();
    t_send_byte();
    t_cmd_write();
    t_recv_byte();
    t_quick_rd();
    t_rd_one_cmd();
    t_rd_multi_cmd();
    t_rd_empty();
    t_bad_starts();
    t_unexp_stop();
    t_overflow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule